// File: doc/BRIEF.md
# Half-Bridge Gate Command Logic

This block sits between a controller and the gate drivers of a half-bridge. It takes an active-low shutdown, a low-side on request and a high-side on request, and produces one gate command for each switch. The two switches may never be commanded on together. When both requests are high, both commands go off. A protection enable from elsewhere on the chip can also force both commands off.

Every input first passes through a two-flop synchronizer. The low-side on-pulse and the high-side off-gap are each shaped by a minimum-width rule. A pulse shorter than `TBLANK_CYC` clock cycles is discarded. A pulse that qualifies is held until `TMIN_CYC` cycles after its leading edge. Qualification waits for the blanking window, so the shaped edge lags the request by that window.

If both switches would end up on, for example because a high-side request arrives while a low-side stretch is still running, the stretch is aborted at once. Both commands are off for that cycle. All timing is counted in cycles of the single clock.

Top module: `hb_gate_cmd`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both gate outputs are 0.
- R2: A low level on `shdn_n_i` drives both gate outputs to 0 from the third rising edge after it is applied, whatever the requests are.
- R3: A low level on `prot_en_i` drives both gate outputs to 0 from the third rising edge after it is applied.
- R4: With shutdown high, enable high and only `hi_req_i` high, `gate_hi_o` is 1 from the fourth rising edge after the request. With only `lo_req_i` high, `gate_lo_o` is 1 from rising edge `TBLANK_CYC`+3. With no request, both outputs are 0.
- R5: While both requests are high, both gate outputs are 0.
- R6: `gate_lo_o` and `gate_hi_o` are never 1 in the same cycle.
- R7: A low-side request lasting fewer than `TBLANK_CYC` cycles never sets `gate_lo_o`.
- R8: A low-side request of L cycles, with `TBLANK_CYC` <= L < `TMIN_CYC`, gives a `gate_lo_o` pulse of `TMIN_CYC`-`TBLANK_CYC`+1 cycles.
- R9: A low-side request of L >= `TMIN_CYC` cycles gives a `gate_lo_o` pulse of L-`TBLANK_CYC`+1 cycles.
- R10: A gap of fewer than `TBLANK_CYC` cycles in `hi_req_i` leaves `gate_hi_o` at 1 throughout.
- R11: A gap of G cycles in `hi_req_i`, with `TBLANK_CYC` <= G < `TMIN_CYC`, holds `gate_hi_o` at 0 for `TMIN_CYC`-`TBLANK_CYC`+1 cycles.
- R12: If the high-side request rises while a low-side stretch is running, `gate_lo_o` drops within one cycle of the conflict and does not come back for that pulse. `gate_hi_o` follows two cycles later.
- R13: The output sequence matches, on every cycle, a reference built from R1 to R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| shdn_n_i | input | 1 | Shutdown, active low |
| lo_req_i | input | 1 | Low-side on request, active high |
| hi_req_i | input | 1 | High-side on request, active high |
| prot_en_i | input | 1 | Enable from protection logic; low forces both gates off |
| gate_lo_o | output | 1 | Low-side gate command |
| gate_hi_o | output | 1 | High-side gate command |

## Verification
The hardest case to reach is the conflict inside a stretch. The low-side request has already dropped, but the shaped command is still being held on. Only then does the high-side request arrive. The bench sends a 50-cycle low-side request, lets it go, and raises the high-side request 70 cycles after the first edge. That point lies inside the held window, which runs to cycle 123. The bench then checks the exact cycles at which the low side is cut off and the high side comes on, and that the low side does not return.

// File: rtl/hb_cmd_pkg.sv
package hb_cmd_pkg;

  typedef enum logic [1:0] {
    SHP_IDLE = 2'd0,
    SHP_QUAL = 2'd1,
    SHP_HOLD = 2'd2
  } shp_state_e;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/hb_pulse_shaper.sv
// Shapes the active phase of req_i. A phase shorter than TBLANK_CYC samples
// is dropped. A qualified phase is held until TMIN_CYC cycles after its edge.
// Reset and abort move the shaper to its safe state: idle (output 0) or
// saturated hold (output 1), picked by SAFE_ACTIVE.
module hb_pulse_shaper
  import hb_cmd_pkg::*;
#(
  parameter int TMIN_CYC    = 120,
  parameter int TBLANK_CYC  = 30,
  parameter bit SAFE_ACTIVE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic abort_i,
  output logic shaped_o
);

  localparam int          CW         = $clog2(TMIN_CYC + 1);
  localparam logic [CW-1:0] TMIN_C   = CW'(TMIN_CYC);
  localparam logic [CW-1:0] BLANK_LAST = CW'(TBLANK_CYC - 1);
  localparam shp_state_e  ENTRY_ST   = (TBLANK_CYC <= 1) ? SHP_HOLD : SHP_QUAL;

  shp_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  shp_state_e    safe_st;
  logic [CW-1:0] safe_cnt;

  generate
    if (SAFE_ACTIVE) begin : g_safe_hold
      assign safe_st  = SHP_HOLD;
      assign safe_cnt = TMIN_C;
    end else begin : g_safe_idle
      assign safe_st  = SHP_IDLE;
      assign safe_cnt = '0;
    end
  endgenerate

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (abort_i) begin
      st_n  = safe_st;
      cnt_n = safe_cnt;
    end else begin
      unique case (st_q)
        SHP_IDLE: begin
          if (req_i) begin
            st_n  = ENTRY_ST;
            cnt_n = CW'(1);
          end
        end
        SHP_QUAL: begin
          if (!req_i) begin
            st_n  = SHP_IDLE;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + CW'(1);
            if (cnt_q == BLANK_LAST) st_n = SHP_HOLD;
          end
        end
        SHP_HOLD: begin
          if (!req_i && (cnt_q >= TMIN_C)) begin
            st_n  = SHP_IDLE;
            cnt_n = '0;
          end else if (cnt_q < TMIN_C) begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        default: begin
          st_n  = safe_st;
          cnt_n = safe_cnt;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= safe_st;
      cnt_q <= safe_cnt;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign shaped_o = (st_q == SHP_HOLD);

endmodule

// File: rtl/hb_gate_cmd.sv
module hb_gate_cmd #(
  parameter int TMIN_CYC   = 120,
  parameter int TBLANK_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n_i,
  input  logic lo_req_i,
  input  logic hi_req_i,
  input  logic prot_en_i,
  output logic gate_lo_o,
  output logic gate_hi_o
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0] sync_q;
  logic lo_s, hi_s, sd_s, en_s;
  logic lo_cmd, gap_cmd, hi_cmd;
  logic conflict, allow;
  logic gate_lo_n, gate_hi_n;

  hb_sync #(.W(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({prot_en_i, shdn_n_i, hi_req_i, lo_req_i}),
    .q_o   (sync_q)
  );

  assign lo_s = sync_q[0];
  assign hi_s = sync_q[1];
  assign sd_s = sync_q[2];
  assign en_s = sync_q[3];

  // Low side: on-pulse shaping, safe state is off.
  hb_pulse_shaper #(
    .TMIN_CYC    (TMIN_CYC),
    .TBLANK_CYC  (TBLANK_CYC),
    .SAFE_ACTIVE (1'b0)
  ) u_lo_shp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (lo_s),
    .abort_i  (conflict),
    .shaped_o (lo_cmd)
  );

  // High side: off-gap shaping, safe state is a held gap (switch off).
  hb_pulse_shaper #(
    .TMIN_CYC    (TMIN_CYC),
    .TBLANK_CYC  (TBLANK_CYC),
    .SAFE_ACTIVE (1'b1)
  ) u_hi_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (~hi_s),
    .abort_i  (conflict),
    .shaped_o (gap_cmd)
  );

  assign hi_cmd = ~gap_cmd;

  always_comb begin
    conflict  = (lo_s & hi_s) | (lo_cmd & hi_cmd);
    allow     = sd_s & en_s;
    gate_lo_n = allow & lo_cmd & ~conflict;
    gate_hi_n = allow & hi_cmd & ~conflict;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_lo_o <= 1'b0;
      gate_hi_o <= 1'b0;
    end else begin
      gate_lo_o <= gate_lo_n;
      gate_hi_o <= gate_hi_n;
    end
  end

endmodule

// File: rtl/hb_gate_cmd_chk.sv
module hb_gate_cmd_chk (
  input logic clk,
  input logic rst_n,
  input logic gate_lo,
  input logic gate_hi,
  input logic lo_s,
  input logic hi_s,
  input logic sd_s,
  input logic en_s,
  input logic lo_cmd,
  input logic hi_cmd
);

  // R6
  never_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lo && gate_hi));

  // R2
  shdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_s |=> (!gate_lo && !gate_hi));

  // R3
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!gate_lo && !gate_hi));

  // R5
  both_req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_s && hi_s) |=> (!gate_lo && !gate_hi));

  // R12
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cmd && hi_cmd) |=> (!lo_cmd && !hi_cmd));

endmodule

bind hb_gate_cmd hb_gate_cmd_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gate_lo (gate_lo_o),
  .gate_hi (gate_hi_o),
  .lo_s    (lo_s),
  .hi_s    (hi_s),
  .sd_s    (sd_s),
  .en_s    (en_s),
  .lo_cmd  (lo_cmd),
  .hi_cmd  (hi_cmd)
);

// File: tb/hb_gate_cmd_bench.sv
`timescale 1ns/1ps
module hb_gate_cmd_bench;

  localparam int TMIN = 120;
  localparam int TBL  = 30;

  logic clk = 1'b0;
  logic rst_n, shdn_n, lo_req, hi_req, prot_en;
  logic gate_lo, gate_hi;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  hb_gate_cmd #(.TMIN_CYC(TMIN), .TBLANK_CYC(TBL)) u_hb_gate_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .shdn_n_i  (shdn_n),
    .lo_req_i  (lo_req),
    .hi_req_i  (hi_req),
    .prot_en_i (prot_en),
    .gate_lo_o (gate_lo),
    .gate_hi_o (gate_hi)
  );

  // Behavioural reference: sampled-input queue plus per-channel age tracking.
  bit [3:0] in_q[$];
  int  lo_age, gp_age;
  bit  lo_q, gp_q;
  bit  m_lo, m_hi;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic shp_ref(input bit a, input bit ab, input bit safe,
                         inout int age, inout bit q);
    if (ab) begin
      if (safe) begin age = TMIN; q = 1; end
      else begin age = -1; q = 0; end
    end else if (!q && age < 0) begin
      if (a) begin age = 0; q = (TBL <= 1); end
    end else if (!q) begin
      if (!a) age = -1;
      else begin age++; if (age == TBL - 1) q = 1; end
    end else begin
      if (age < TMIN) age++;
      if (!a && age >= TMIN) begin q = 0; age = -1; end
    end
  endtask

  task automatic model_edge();
    bit [3:0] s;
    bit lo_c, hi_c, c, nlo, nhi;
    if (!rst_n) begin
      in_q = '{4'b0, 4'b0};
      lo_age = -1; lo_q = 0; gp_age = TMIN; gp_q = 1;
      m_lo = 0; m_hi = 0;
    end else begin
      s = in_q[0];
      lo_c = lo_q; hi_c = !gp_q;
      c = (s[0] & s[1]) | (lo_c & hi_c);
      nlo = s[2] & s[3] & lo_c & !c;
      nhi = s[2] & s[3] & hi_c & !c;
      shp_ref(s[0], c, 1'b0, lo_age, lo_q);
      shp_ref(!s[1], c, 1'b1, gp_age, gp_q);
      m_lo = nlo; m_hi = nhi;
      void'(in_q.pop_front());
      in_q.push_back({prot_en, shdn_n, hi_req, lo_req});
    end
  endtask

  // One clock: reference steps on the edge, outputs compared mid-cycle.
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(gate_lo === m_lo && gate_hi === m_hi, cur_req, "lo/hi vs reference (R13)",
        {gate_lo, gate_hi}, {m_lo, m_hi});
    chk(!(gate_lo && gate_hi), "R6", "both gates on", 1, 0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  // Low-side request of len cycles; returns first-on step and on width.
  task automatic lo_pulse(input int len, input int win,
                          output int first, output int width);
    first = -1; width = 0;
    lo_req = 1;
    for (int k = 1; k <= win; k++) begin
      if (k == len + 1) lo_req = 0;
      step();
      if (gate_lo) begin width++; if (first < 0) first = k; end
    end
  endtask

  // High-side gap of len cycles (hi_req high beforehand); returns off width.
  task automatic hi_gap(input int len, input int win, output int width);
    width = 0;
    hi_req = 0;
    for (int k = 1; k <= win; k++) begin
      if (k == len + 1) hi_req = 1;
      step();
      if (!gate_hi) width++;
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int first, width, cnt;
    rst_n = 0; shdn_n = 1; lo_req = 0; hi_req = 0; prot_en = 1;
    // R1
    cur_req = "R1";
    idle(3);
    chk(!gate_lo && !gate_hi, "R1", "outputs in reset", {gate_lo, gate_hi}, 0);
    rst_n = 1;
    idle(1);
    chk(!gate_lo && !gate_hi, "R1", "outputs after reset", {gate_lo, gate_hi}, 0);
    idle(10);

    // R4 high side only
    cur_req = "R4";
    hi_req = 1;
    idle(3);
    chk(gate_hi == 0, "R4", "hi at edge 3", gate_hi, 0);
    idle(1);
    chk(gate_hi == 1, "R4", "hi at edge 4", gate_hi, 1);
    idle(20);

    // R10 short gap ignored
    cur_req = "R10";
    hi_gap(10, 60, width);
    chk(width == 0, "R10", "hi off cycles for short gap", width, 0);

    // R11 medium gap stretched
    cur_req = "R11";
    hi_gap(50, 200, width);
    chk(width == TMIN - TBL + 1, "R11", "hi off width", width, TMIN - TBL + 1);

    // R2 shutdown while high side on
    cur_req = "R2";
    shdn_n = 0;
    idle(2);
    chk(gate_hi == 1, "R2", "hi at edge 2 of shutdown", gate_hi, 1);
    idle(1);
    chk(gate_hi == 0, "R2", "hi at edge 3 of shutdown", gate_hi, 0);
    idle(10);
    shdn_n = 1;
    idle(5);
    chk(gate_hi == 1, "R2", "hi back after shutdown", gate_hi, 1);
    hi_req = 0;
    idle(TMIN + 20);

    // R7 blanked low pulse
    cur_req = "R7";
    lo_pulse(10, 80, first, width);
    chk(width == 0, "R7", "lo on cycles for short pulse", width, 0);
    idle(20);

    // R8 stretched low pulse, R4 low-side latency
    cur_req = "R8";
    lo_pulse(50, TMIN + 60, first, width);
    chk(first == TBL + 3, "R4", "lo first-on edge", first, TBL + 3);
    chk(width == TMIN - TBL + 1, "R8", "lo stretched width", width, TMIN - TBL + 1);
    idle(20);

    // R9 long low pulse follows release
    cur_req = "R9";
    lo_pulse(200, 260, first, width);
    chk(width == 200 - TBL + 1, "R9", "lo long width", width, 200 - TBL + 1);
    idle(20);

    // R5 both requests
    cur_req = "R5";
    lo_req = 1; hi_req = 1;
    cnt = 0;
    for (int k = 0; k < 80; k++) begin
      step();
      if (gate_lo || gate_hi) cnt++;
    end
    chk(cnt == 0, "R5", "on cycles with both requests", cnt, 0);
    lo_req = 0; hi_req = 0;
    idle(TMIN + 20);

    // R12 conflict during low-side stretch
    cur_req = "R12";
    cnt = 0;
    lo_req = 1;
    for (int k = 1; k <= 160; k++) begin
      if (k == 51) lo_req = 0;
      if (k == 70) hi_req = 1;
      step();
      if (k == 72) chk(gate_lo == 1, "R12", "lo still on before conflict", gate_lo, 1);
      if (k == 73) chk(gate_lo == 0, "R12", "lo cut by conflict", gate_lo, 0);
      if (k == 74) chk(gate_hi == 0, "R12", "hi off during abort", gate_hi, 0);
      if (k == 75) chk(gate_hi == 1, "R12", "hi on after abort", gate_hi, 1);
      if (k >= 73 && gate_lo) cnt++;
    end
    chk(cnt == 0, "R12", "lo on cycles after abort", cnt, 0);
    hi_req = 0;
    idle(TMIN + 20);

    // R3 protection enable while low side on
    cur_req = "R3";
    lo_req = 1;
    idle(TBL + 10);
    chk(gate_lo == 1, "R3", "lo on before disable", gate_lo, 1);
    prot_en = 0;
    idle(2);
    chk(gate_lo == 1, "R3", "lo at edge 2 of disable", gate_lo, 1);
    idle(1);
    chk(gate_lo == 0, "R3", "lo at edge 3 of disable", gate_lo, 0);
    idle(10);
    prot_en = 1;
    idle(5);
    chk(gate_lo == 1, "R3", "lo back after enable", gate_lo, 1);
    lo_req = 0;
    idle(TMIN + 10);
    chk(!gate_lo && !gate_hi, "R4", "no request gives both off", {gate_lo, gate_hi}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule